// File: doc/BRIEF.md
# Audio Master-Clock Enable Regenerator

This block rebuilds an audio master-clock enable inside the link pixel-clock domain. The transmitter sends a numerator N and a denominator CTS. The link clock divided by CTS and multiplied by N gives 128 times the audio sample rate. The block holds the latest pair and adds N times a small multiple to a phase accumulator on every clock. Each time the phase reaches CTS it takes CTS back off and emits a one-cycle enable pulse. Over time the average pulse rate is f_clk·N·k/CTS.

A select input picks the multiple of the sample rate: 128, 256, 384 or 512 times fs. Downstream audio serializers use the enable as their master-clock tick. Loading a new pair does not clear the accumulated phase, so a rate update made during playback causes no phase jump. A zero denominator silences the output.

Top module: `acr_clock_regen`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears mclk_en, the accumulated phase and the stored N/CTS pair. With no pair loaded after reset, mclk_en stays low.
- R2: The block captures the 20-bit ratio_n and 20-bit ratio_cts together on a clock edge where ratio_load is high. Between strobes the stored pair holds.
- R3: The multiple k added per clock is taken from fs_sel: 3'b000 gives k=1 (128·fs), 3'b001 gives k=2 (256·fs), 3'b010 gives k=3 (384·fs) and 3'b011 gives k=4 (512·fs).
- R4: fs_sel codes 3'b100 through 3'b111 behave exactly like 3'b000 (k=1).
- R5: Start from zero phase with N·k < CTS. Over the M clock edges that follow the loading edge, mclk_en is high after exactly floor(M·N·k/CTS) of them.
- R6: While the stored CTS is zero, mclk_en stays low whatever N and fs_sel are.
- R7: A load does not clear the phase. The loading edge itself still accumulates with the previous pair, and the new pair applies from the next edge on.
- R8: When N·k ≥ CTS with CTS nonzero, mclk_en is high after every clock edge. After each step the phase is kept below CTS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_load | input | 1 | Strobe: capture ratio_n and ratio_cts this edge |
| ratio_n | input | 20 | Regeneration numerator N |
| ratio_cts | input | 20 | Regeneration denominator CTS |
| fs_sel | input | 3 | Multiple of fs select |
| mclk_en | output | 1 | One-cycle audio master-clock enable |

## Verification
The hardest case to reach from the ports is a reload that lands while the accumulator holds a partial, nonzero phase. Only the timing of later pulses shows whether that phase survived. The stimulus loads a small pair (N=1, CTS=4) and runs two cycles so the phase sits at 2. It then loads N=1, CTS=5 and checks that the first pulse comes on the second edge after the loading edge. A block that cleared the phase would pulse three edges later. Long runs with real-world ratios confirm the exact pulse count for every fs_sel code.

// File: rtl/acr_pkg.sv
// Shared constants and the select-to-multiple decode for the audio
// master-clock regenerator. Assumes a 3-bit select and multiples of 1..4.
package acr_pkg;
    localparam int ACR_SEL_W = 3;
    localparam int ACR_K_W   = 3;

    // Map the fs select code to the per-clock multiple (unused codes -> 1).
    function automatic logic [ACR_K_W-1:0] mult_of_sel(input logic [ACR_SEL_W-1:0] sel);
        case (sel)
            3'b001:  mult_of_sel = 3'd2;
            3'b010:  mult_of_sel = 3'd3;
            3'b011:  mult_of_sel = 3'd4;
            default: mult_of_sel = 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/acr_ratio_regs.sv
// Holds the N/CTS pair. Both words are captured together on the load
// strobe so the accumulator never sees a mixed pair.
// Assumes the load strobe is synchronous to clk.
module acr_ratio_regs #(
    parameter int N_W   = 20,
    parameter int CTS_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [N_W-1:0]   n_i,
    input  logic [CTS_W-1:0] cts_i,
    output logic [N_W-1:0]   n_o,
    output logic [CTS_W-1:0] cts_o
);
    // Capture register for the ratio pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_o   <= '0;
            cts_o <= '0;
        end else if (ld_i) begin
            n_o   <= n_i;
            cts_o <= cts_i;
        end
    end

    assert_pair_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (n_o == $past(n_i)) && (cts_o == $past(cts_i)));

    assert_pair_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(n_o) && $stable(cts_o));
endmodule

// File: rtl/acr_step_gen.sv
// Forms the per-clock phase increment N*k from the stored numerator and
// the fs select. Purely combinational; assumes k never exceeds 4.
module acr_step_gen
    import acr_pkg::*;
#(
    parameter int N_W = 20,
    localparam int STEP_W = N_W + ACR_K_W
) (
    input  logic [N_W-1:0]       n_i,
    input  logic [ACR_SEL_W-1:0] sel_i,
    output logic [STEP_W-1:0]    step_o
);
    logic [ACR_K_W-1:0] mult;

    // Decode the multiple and scale the numerator by it.
    always_comb begin
        mult   = mult_of_sel(sel_i);
        step_o = STEP_W'(n_i) * STEP_W'(mult);
    end
endmodule

// File: rtl/acr_phase_acc.sv
// Fractional phase accumulator. Adds the step each clock. When the sum
// reaches CTS it takes CTS off once and raises a one-cycle pulse. If one
// subtraction is not enough (step >= CTS, or CTS shrank on a reload), the
// phase restarts at zero so it stays bounded. CTS of zero freezes the phase
// and keeps the pulse low.
module acr_phase_acc #(
    parameter int CTS_W  = 20,
    parameter int STEP_W = 23,
    localparam int SUM_W = ((STEP_W > CTS_W) ? STEP_W : CTS_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTS_W-1:0]  cts_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              pulse_o
);
    logic [CTS_W-1:0] acc_q, acc_d;
    logic [SUM_W-1:0] sum, rem, cts_ext;
    logic             hit;

    // Next-phase computation with a single wrap per clock.
    always_comb begin
        cts_ext = SUM_W'(cts_i);
        sum     = SUM_W'(acc_q) + SUM_W'(step_i);
        rem     = sum - cts_ext;
        hit     = (cts_i != '0) && (sum >= cts_ext);
        acc_d   = acc_q;
        if (cts_i != '0) begin
            if (!hit)
                acc_d = CTS_W'(sum);
            else if (rem >= cts_ext)
                acc_d = '0;
            else
                acc_d = CTS_W'(rem);
        end
    end

    // Phase and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            pulse_o <= hit;
        end
    end

    assert_silent_zero_cts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_i == '0) |=> !pulse_o);

    assert_overrun_every_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cts_i != '0) && (SUM_W'(step_i) >= SUM_W'(cts_i))) |=> pulse_o);

    assert_phase_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_i != '0) |=> (acc_q < $past(cts_i)));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !pulse_o && (acc_q == '0));
endmodule

// File: rtl/acr_clock_regen.sv
// Audio master-clock enable regenerator: ratio registers, step generator
// and phase accumulator in series. The output is one registered pulse per
// regenerated master-clock period, in the clk domain.
// Assumes fs_sel is synchronous to clk.
module acr_clock_regen
    import acr_pkg::*;
#(
    parameter int N_W   = 20,
    parameter int CTS_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ratio_load,
    input  logic [N_W-1:0]       ratio_n,
    input  logic [CTS_W-1:0]     ratio_cts,
    input  logic [ACR_SEL_W-1:0] fs_sel,
    output logic                 mclk_en
);
    localparam int STEP_W = N_W + ACR_K_W;

    logic [N_W-1:0]    n_q;
    logic [CTS_W-1:0]  cts_q;
    logic [STEP_W-1:0] step;

    acr_ratio_regs #(.N_W(N_W), .CTS_W(CTS_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_i  (ratio_load),
        .n_i   (ratio_n),
        .cts_i (ratio_cts),
        .n_o   (n_q),
        .cts_o (cts_q)
    );

    acr_step_gen #(.N_W(N_W)) u_step (
        .n_i    (n_q),
        .sel_i  (fs_sel),
        .step_o (step)
    );

    acr_phase_acc #(.CTS_W(CTS_W), .STEP_W(STEP_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_i   (cts_q),
        .step_i  (step),
        .pulse_o (mclk_en)
    );
endmodule

// File: tb/acr_clock_regen_test.sv
// Self-checking bench: a vector table of ratio/select/length runs with the
// pulse count predicted from floor(M*N*k/CTS), then directed corner cases.
module acr_clock_regen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ratio_load = 1'b0;
    logic [19:0] ratio_n = '0;
    logic [19:0] ratio_cts = '0;
    logic [2:0]  fs_sel = '0;
    logic        mclk_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    acr_clock_regen uut (
        .clk(clk), .rst_n(rst_n), .ratio_load(ratio_load),
        .ratio_n(ratio_n), .ratio_cts(ratio_cts), .fs_sel(fs_sel),
        .mclk_en(mclk_en)
    );

    // {N[58:39], CTS[38:19], sel[18:16], cycles[15:0]}
    localparam logic [58:0] VEC [8] = '{
        {20'd6144, 20'd25000, 3'd0, 16'd1000},
        {20'd6144, 20'd25000, 3'd1, 16'd1000},
        {20'd6144, 20'd25000, 3'd2, 16'd1000},
        {20'd6144, 20'd25000, 3'd3, 16'd1000},
        {20'd6144, 20'd25000, 3'd4, 16'd1000},
        {20'd6144, 20'd25000, 3'd7, 16'd1000},
        {20'd4096, 20'd27000, 3'd3, 16'd1000},
        {20'd1,    20'd3,     3'd0, 16'd30}
    };

    function automatic int k_of(input logic [2:0] s);
        case (s)
            3'b001:  return 2;
            3'b010:  return 3;
            3'b011:  return 4;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ratio_load = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic load_pair(input logic [19:0] n, input logic [19:0] c);
        ratio_n = n;
        ratio_cts = c;
        ratio_load = 1'b1;
        @(posedge clk);
        #1 ratio_load = 1'b0;
    endtask

    task automatic count_pulses(input int m, output int cnt);
        cnt = 0;
        for (int j = 0; j < m; j++) begin
            @(posedge clk);
            #1 if (mclk_en) cnt++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        do_reset();
        // R1: reset state, and no pulses with nothing loaded
        check("R1 reset mclk_en", mclk_en, 0);
        count_pulses(20, cnt);
        check("R1 idle after reset", cnt, 0);

        // R3 R4 R5: table of ratio runs
        for (int v = 0; v < 8; v++) begin
            logic [19:0] n, c;
            logic [2:0]  s;
            int m;
            longint exp;
            n = VEC[v][58:39];
            c = VEC[v][38:19];
            s = VEC[v][18:16];
            m = int'(VEC[v][15:0]);
            fs_sel = s;
            do_reset();
            load_pair(n, c);
            count_pulses(m, cnt);
            exp = (longint'(m) * longint'(n) * longint'(k_of(s))) / longint'(c);
            check((s > 3) ? "R4 unused sel" : ((v == 0 || v == 7) ? "R5 count" : "R3 multiple"),
                  cnt, exp);
        end

        // R1: reset during activity clears output
        fs_sel = 3'd3;
        load_pair(20'd9, 20'd10);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check("R1 reset mid-run", mclk_en, 0);
        rst_n = 1'b1;
        count_pulses(10, cnt);
        check("R1 pair cleared by reset", cnt, 0);

        // R6: zero CTS keeps output low
        fs_sel = 3'd0;
        do_reset();
        load_pair(20'd5000, 20'd0);
        count_pulses(100, cnt);
        check("R6 zero cts", cnt, 0);

        // R8: N*k >= CTS gives a pulse every edge
        do_reset();
        load_pair(20'd10, 20'd10);
        count_pulses(50, cnt);
        check("R8 equal ratio", cnt, 50);
        do_reset();
        fs_sel = 3'd3;
        load_pair(20'd30, 20'd10);
        count_pulses(50, cnt);
        check("R8 large ratio", cnt, 50);

        // R2 R7: reload keeps phase; load edge uses old pair
        fs_sel = 3'd0;
        do_reset();
        load_pair(20'd1, 20'd4);
        count_pulses(2, cnt);           // phase now 2
        check("R7 no early pulse", cnt, 0);
        load_pair(20'd1, 20'd5);        // old pair: phase 3
        #0 check("R7 load edge", mclk_en, 0);
        @(posedge clk); #1 check("R7 first edge after load", mclk_en, 0);
        @(posedge clk); #1 check("R7 second edge after load", mclk_en, 1);
        // R2: inputs changing without strobe have no effect (period stays 5)
        ratio_n = 20'd4;
        ratio_cts = 20'd5;
        count_pulses(50, cnt);
        check("R2 held pair", cnt, 10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule